// File: doc/BRIEF.md
# SAR ADC Digital Controller

This block is the digital sequencer of a 10-bit successive-approximation converter serving 12 multiplexed analog inputs. It selects the input channel, opens a fixed sampling window, then walks a trial code from the most significant bit down to the least significant bit. It presents each trial code to an external resistor-string DAC and reads back a single comparator decision for each step. The analog front end, the DAC and the comparator sit outside the block.

Software controls the block through a small write-only register port with two registers. The mode register starts a conversion and selects single-shot or free-running operation. The channel register picks the input. Any write to either register cancels a conversion in flight. A finished code is placed left-justified in a 16-bit result word, and a separate 8-bit view returns the upper byte of that word. A one-cycle completion strobe and a sticky end flag mark each new result. Strobing the result-read input clears the end flag.

The sequencer has three states. IDLE waits for a start. SAMPLE lasts 4 clocks with the hold output low. COMPARE lasts 10 clocks, one bit per clock. The transitions are:
- IDLE→SAMPLE on a mode write with the start bit set.
- SAMPLE→COMPARE when the sample count reaches its last value.
- COMPARE→SAMPLE after the final bit when the free-run bit is set.
- COMPARE→IDLE after the final bit when the free-run bit is clear.
- Any state→IDLE on a register write that does not request a start.
- Any state→SAMPLE on a mode write that requests a start, which restarts the conversion.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Reset sets `chan_sel` to 0. A write to the channel register (`reg_addr`=1) with a value from 0 to 11 appears on `chan_sel` one clock later.
- R2: A channel-register write with a value of 12 or more is ignored, and `chan_sel` keeps its previous value.
- R3: A mode-register write (`reg_addr`=0) with bit 0 set starts a conversion. `hold_en` is low for the 4 clocks after the write edge and then high for 10 compare clocks. The result loads on the 14th clock edge after the write edge.
- R4: During a compare step, `dac_code` equals the bits already decided, with the current bit set to 1 and all lower bits 0. A `cmp_in` of 1 keeps the trial bit and a 0 clears it. The first trial code is 0x200.
- R5: `result` keeps its previous value for the whole conversion and changes only at the completion edge.
- R6: `result[15:6]` holds the 10-bit code and `result[5:0]` always reads 0.
- R7: `result_hi` always equals `result[15:8]`.
- R8: After reset, `result` is 0x0000, `result_hi` is 0x00, and `conv_done`, `eoc` and `hold_en` are all 0.
- R9: A write to either register during a conversion aborts it, and `result` is not updated from the partial code. A mode write with bit 0 set restarts a full 14-clock conversion. Any other write returns the block to idle.
- R10: `conv_done` is high for exactly one clock when `result` updates, and `eoc` is set at the same time. A `res_rd` strobe clears `eoc` on the next clock. If a completion and a `res_rd` fall on the same edge, `eoc` ends up set.
- R11: With mode bit 1 (free-run) set, a new conversion on the same channel follows each completion, so results arrive every 14 clocks. With bit 1 clear, the block goes idle after one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode register, 1 = channel register |
| reg_wdata | input | 8 | Write data (mode: bit 0 start, bit 1 free-run) |
| res_rd | input | 1 | Result read strobe, clears `eoc` |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| chan_sel | output | 4 | Selected analog channel |
| dac_code | output | 10 | Trial code to the resistor-string DAC |
| hold_en | output | 1 | Hold enable, low while sampling |
| result | output | 16 | Left-justified conversion result |
| result_hi | output | 8 | Upper byte of `result` |
| conv_done | output | 1 | One-clock completion strobe |
| eoc | output | 1 | Sticky end-of-conversion flag |

## Verification
Two functions can act on the end flag in the same cycle: a completion tries to set it, and a result read tries to clear it. The bench arranges this by raising `res_rd` in the clock just before the 14th edge of a conversion, so the read and the final bit decision are taken on one edge. The outcome is judged by checking that `eoc` is still high afterwards and that a later lone read clears it. A second coincidence, an abort write landing mid-conversion, is judged by checking that no completion strobe and no result change follow.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_COMPARE = 2'd2
    } seq_state_t;

    localparam logic ADDR_MODE     = 1'b0;
    localparam logic ADDR_CHAN     = 1'b1;
    localparam int   MODE_START_B  = 0;
    localparam int   MODE_FREERUN_B = 1;
endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
    import sar_adc_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int DW     = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic            abort,
    output logic            start,
    output logic            freerun,
    output logic [CH_W-1:0] chan
);
    localparam logic [DW-1:0] CH_LIMIT = DW'(NUM_CH);

    logic mode_wr;
    logic chan_wr;

    always_comb begin
        mode_wr = wr && (addr == ADDR_MODE);
        chan_wr = wr && (addr == ADDR_CHAN);
        abort   = wr;
        start   = mode_wr && wdata[MODE_START_B];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freerun <= 1'b0;
            chan    <= '0;
        end else begin
            if (mode_wr) freerun <= wdata[MODE_FREERUN_B];
            if (chan_wr && (wdata < CH_LIMIT)) chan <= wdata[CH_W-1:0];
        end
    end

    // R1: channel never leaves the legal range
    p_chan_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chan < CH_W'(NUM_CH));
    // R2: out-of-range channel write leaves the channel unchanged
    p_chan_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_wr && wdata >= CH_LIMIT) |=> $stable(chan));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int SMP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic             freerun,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             hold_en,
    output logic             fin_valid,
    output logic [RES_W-1:0] fin_code
);
    localparam int BIT_W = $clog2(RES_W);
    localparam int CNT_W = $clog2(SMP_CYC) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SMP_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(RES_W - 1);

    seq_state_t       st, st_n;
    logic [CNT_W-1:0] smp_cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [RES_W-1:0] decided;
    logic [RES_W-1:0] trial;
    logic             enter_smp;

    // next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:    st_n = ST_IDLE;
            ST_SAMPLE:  if (smp_cnt == CNT_LAST) st_n = ST_COMPARE;
            ST_COMPARE: if (bit_idx == '0) st_n = freerun ? ST_SAMPLE : ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
        if (abort) st_n = start ? ST_SAMPLE : ST_IDLE;
        enter_smp = (st_n == ST_SAMPLE) && (abort || st != ST_SAMPLE);
    end

    // state register and SAR datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            smp_cnt <= '0;
            bit_idx <= '0;
            decided <= '0;
        end else begin
            st <= st_n;
            if (enter_smp) begin
                smp_cnt <= '0;
                decided <= '0;
            end else if (abort) begin
                decided <= '0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_SAMPLE: begin
                        smp_cnt <= smp_cnt + 1'b1;
                        if (st_n == ST_COMPARE) begin
                            bit_idx <= BIT_TOP;
                            decided <= '0;
                        end
                    end
                    ST_COMPARE: begin
                        decided[bit_idx] <= cmp_in;
                        if (bit_idx != '0) bit_idx <= bit_idx - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        trial     = (st == ST_COMPARE) ? (RES_W'(1) << bit_idx) : '0;
        dac_code  = decided | trial;
        hold_en   = (st == ST_COMPARE);
        fin_valid = (st == ST_COMPARE) && (bit_idx == '0) && !abort;
        fin_code  = decided | (cmp_in ? trial : '0);
    end

    // R3: after the last sample clock the first trial (MSB) is presented with hold high
    p_first_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE && smp_cnt == CNT_LAST && !abort)
            |=> (hold_en && dac_code == (RES_W'(1) << (RES_W - 1))));
    // R4: a kept trial bit stays set in the decided code
    p_keep_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMPARE && bit_idx != '0 && cmp_in && !abort)
            |=> ((decided & $past(trial)) != '0));
    // R4: exactly one undecided trial bit drives the DAC while comparing
    p_one_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |-> ($countones(dac_code ^ decided) == 1));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16,
    parameter int HI_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_valid,
    input  logic [RES_W-1:0] fin_code,
    input  logic             rd,
    output logic [OUT_W-1:0] result,
    output logic [HI_W-1:0]  result_hi,
    output logic             done,
    output logic             eoc
);
    localparam int PAD_W = OUT_W - RES_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
            eoc    <= 1'b0;
        end else begin
            done <= fin_valid;
            if (fin_valid) result <= {fin_code, {PAD_W{1'b0}}};
            if (fin_valid)  eoc <= 1'b1;
            else if (rd)    eoc <= 1'b0;
        end
    end

    always_comb result_hi = result[OUT_W-1 -: HI_W];

    // R5: result is held whenever no completion is signalled
    p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_valid |=> $stable(result));
    // R10: completion raises strobe and flag together
    p_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |=> (done && eoc));
    // R10: read without completion clears the flag
    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !fin_valid) |=> !eoc);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int NUM_CH  = 12,
    parameter int RES_W   = 10,
    parameter int OUT_W   = 16,
    parameter int HI_W    = 8,
    parameter int SMP_CYC = 4,
    parameter int DW      = 8,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             res_rd,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  chan_sel,
    output logic [RES_W-1:0] dac_code,
    output logic             hold_en,
    output logic [OUT_W-1:0] result,
    output logic [HI_W-1:0]  result_hi,
    output logic             conv_done,
    output logic             eoc
);
    logic             abort;
    logic             start;
    logic             freerun;
    logic             fin_valid;
    logic [RES_W-1:0] fin_code;

    sar_cfg_regs #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .abort   (abort),
        .start   (start),
        .freerun (freerun),
        .chan    (chan_sel)
    );

    sar_seq #(.RES_W(RES_W), .SMP_CYC(SMP_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .start     (start),
        .freerun   (freerun),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .hold_en   (hold_en),
        .fin_valid (fin_valid),
        .fin_code  (fin_code)
    );

    sar_result #(.RES_W(RES_W), .OUT_W(OUT_W), .HI_W(HI_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin_valid (fin_valid),
        .fin_code  (fin_code),
        .rd        (res_rd),
        .result    (result),
        .result_hi (result_hi),
        .done      (conv_done),
        .eoc       (eoc)
    );

    // R9: a register write never lets a partial code reach the result
    p_abort_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ($stable(result) && !conv_done));
    // R6: the padding bits of the result stay zero
    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result[OUT_W-RES_W-1:0] == '0);
endmodule

// File: tb/sar_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        res_rd = 1'b0;
    logic        cmp_in;
    logic [3:0]  chan_sel;
    logic [9:0]  dac_code;
    logic        hold_en;
    logic [15:0] result;
    logic [7:0]  result_hi;
    logic        conv_done;
    logic        eoc;

    logic [9:0]  tgt_mem [12];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    // ideal comparator against a per-channel target code
    always_comb cmp_in = (tgt_mem[chan_sel] >= dac_code);

    sar_adc_ctrl u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .res_rd(res_rd), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .dac_code(dac_code), .hold_en(hold_en),
        .result(result), .result_hi(result_hi), .conv_done(conv_done), .eoc(eoc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns at the falling edge right after the write edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); res_rd = 1'b1;
        @(negedge clk); res_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 result", result, 32'h0);
        check("R8 result_hi", result_hi, 32'h0);
        check("R8 done", conv_done, 0);
        check("R8 eoc", eoc, 0);
        check("R8 hold", hold_en, 0);
        check("R1 chan reset", chan_sel, 0);
    endtask

    task automatic t_chan();
        wr(1'b1, 8'd5);   check("R1 chan 5", chan_sel, 5);
        wr(1'b1, 8'd12);  check("R2 chan 12 ignored", chan_sel, 5);
        wr(1'b1, 8'd255); check("R2 chan 255 ignored", chan_sel, 5);
        wr(1'b1, 8'd11);  check("R1 chan 11", chan_sel, 11);
    endtask

    task automatic t_convert(input int ch, input logic [9:0] tgt);
        logic [15:0] old;
        tgt_mem[ch] = tgt;
        wr(1'b1, 8'(ch));
        old = result;
        wr(1'b0, 8'h01);
        check("R3 hold low k0", hold_en, 0);
        step(3); check("R3 hold low k3", hold_en, 0);
        step(1);
        check("R3 hold high k4", hold_en, 1);
        check("R4 first trial", dac_code, 10'h200);
        step(1);
        check("R4 second trial", dac_code, (tgt & 10'h200) | 10'h100);
        step(8);
        check("R5 result held k13", result, old);
        check("R10 no done k13", conv_done, 0);
        step(1);
        check("R10 done k14", conv_done, 1);
        check("R6 result", result, {tgt, 6'b0});
        check("R7 result_hi", result_hi, tgt[9:2]);
        step(1);
        check("R10 done one cycle", conv_done, 0);
        check("R10 eoc sticky", eoc, 1);
        check("R11 idle after single", hold_en, 0);
    endtask

    task automatic t_read_clear();
        rd_pulse();
        check("R10 read clears eoc", eoc, 0);
    endtask

    task automatic t_collide();
        tgt_mem[3] = 10'h0F1;
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h01);
        step(13);
        res_rd = 1'b1;
        step(1);
        res_rd = 1'b0;
        check("R10 collide done", conv_done, 1);
        check("R10 collide set wins", eoc, 1);
        check("R6 collide result", result, {10'h0F1, 6'b0});
        t_read_clear();
    endtask

    task automatic t_abort();
        logic [15:0] old;
        int seen;
        tgt_mem[4] = 10'h3C3;
        wr(1'b1, 8'd4);
        old = result;
        wr(1'b0, 8'h01);
        step(6);
        wr(1'b1, 8'd4);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (conv_done) seen++;
        end
        check("R9 abort no done", seen, 0);
        check("R9 abort result kept", result, old);
        check("R9 abort idle", hold_en, 0);
        // restart by a second start write mid conversion
        wr(1'b0, 8'h01);
        step(7);
        wr(1'b0, 8'h01);
        step(13);
        check("R9 restart no early done", conv_done, 0);
        check("R9 restart result held", result, old);
        step(1);
        check("R9 restart done", conv_done, 1);
        check("R9 restart result", result, {10'h3C3, 6'b0});
    endtask

    task automatic t_freerun();
        int seen;
        tgt_mem[2] = 10'h123;
        wr(1'b1, 8'd2);
        wr(1'b0, 8'h03);
        step(14);
        check("R11 first done", conv_done, 1);
        check("R11 first result", result, {10'h123, 6'b0});
        tgt_mem[2] = 10'h2F0;
        step(13);
        check("R11 second not yet", conv_done, 0);
        step(1);
        check("R11 second done", conv_done, 1);
        check("R11 second result", result, {10'h2F0, 6'b0});
        check("R7 second hi", result_hi, 8'hBC);
        wr(1'b0, 8'h00);
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            step(1);
            if (conv_done) seen++;
        end
        check("R11 stopped", seen, 0);
        check("R11 stopped hold", hold_en, 0);
    endtask

    task automatic t_extremes();
        t_convert(0, 10'h000);
        t_convert(1, 10'h3FF);
        check("R7 hi full", result_hi, 8'hFF);
        t_convert(5, 10'h2AA);
        t_convert(6, 10'h155);
        t_convert(7, 10'h200);
        t_convert(8, 10'h1FF);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) tgt_mem[i] = 10'(i * 37);
        step(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_chan();
        t_convert(9, 10'h2C5);
        t_read_clear();
        t_extremes();
        t_collide();
        t_abort();
        t_freerun();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule